// File: doc/BRIEF.md
# 64B/66B All-Control Block Encoder

This block turns one 64-bit word, split into eight byte lanes that each carry a control flag, into a 66-bit block whose bit 0 is the first bit to go out on the line. Since every field is already in line order, a later serializer only has to shift the block out one bit at a time and never reorders anything.

If no lane is flagged as control, the eight data bytes pass through behind a data sync header. If every lane is flagged as control, each control character becomes a 7-bit code, and the block starts with a control sync header followed by a block type byte. Each 7-bit code and each byte keeps its least significant bit at its lowest frame index, so each field occupies one contiguous run of bits. Words that mix data and control lanes are not encoded. They come out as an error block, and any control character that the block does not recognize raises the error flag. The result appears one clock after the word is accepted.

Top module: `enc66_ctl_encoder`

## Requirements
- R1: While reset is active, and on the first clock after it, `out_valid` and `out_err` are 0.
- R2: `out_valid` is 1 in the cycle after a cycle with `in_valid` 1, and 0 in the cycle after a cycle with `in_valid` 0.
- R3: `out_frame` and `out_err` keep their values across a clock edge where `in_valid` is 0.
- R4: If `in_ctrl` is all zeros, `out_frame[0]`=0, `out_frame[1]`=1 and `out_frame[65:2]` equals `in_data`, with lane k (`in_data[8k+7:8k]`) at frame bits 2+8k upward.
- R5: If `in_ctrl` is all ones, `out_frame[0]`=1, `out_frame[1]`=0, and `out_frame[9:2]` holds type byte 0x1E with its bit 0 at frame bit 2 (line order 01111000).
- R6: In a control block, the 7-bit code for lane k sits at `out_frame[16+7k:10+7k]`, with code bit 0 at frame bit 10+7k. Lane 0 comes first on the line.
- R7: The control character mapping is 0x07→0x00, 0xFE→0x1E, 0x1C→0x2D, 0x3C→0x33, 0x7C→0x4B, 0xBC→0x55, 0xDC→0x66, 0xF7→0x78.
- R8: In an all-control word, a lane whose character is outside the R7 table gets code 0x1E and sets `out_err` to 1. The other lanes still map normally.
- R9: A word with both data and control lanes produces a control header, type 0x1E, code 0x1E in all eight lanes, and `out_err`=1.
- R10: `out_err` is 0 for an all-data word and for an all-control word in which every character is in the R7 table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is present this cycle |
| in_data | input | 64 | Eight byte lanes, lane 0 in bits 7:0 |
| in_ctrl | input | 8 | Per-lane control flag, bit k for lane k |
| out_valid | output | 1 | `out_frame` holds a new block |
| out_frame | output | 66 | Encoded block, bit 0 first on the line |
| out_err | output | 1 | Unknown control character or mixed word |

## Verification
All three results (`out_valid`, `out_frame`, `out_err`) come from one register stage, so each one is due at the first rising edge after the word is driven. The bench changes its inputs on a falling edge and reads the outputs at the next falling edge, which is half a cycle after that rising edge. The hold checks leave `in_valid` low for a cycle, change the data and flags, and confirm at the following falling edge that the outputs did not change. The reset checks read the outputs while reset is held and again at the falling edge after reset is released.

// File: rtl/enc66_pkg.sv
package enc66_pkg;
  localparam int LANES     = 8;
  localparam int LANE_W    = 8;
  localparam int CODE_W    = 7;
  localparam int HDR_W     = 2;
  localparam int DATA_W    = LANES * LANE_W;
  localparam int FRAME_W   = HDR_W + DATA_W;
  localparam int CODE_BASE = HDR_W + LANE_W;

  // Header values as vectors: bit 0 goes out first.
  localparam logic [HDR_W-1:0]  HDR_CTL    = 2'b01;
  localparam logic [HDR_W-1:0]  HDR_DAT    = 2'b10;
  localparam logic [LANE_W-1:0] TYPE_ALLCT = 8'h1E;
  localparam logic [CODE_W-1:0] CODE_ERR   = 7'h1E;

  typedef struct packed {
    logic              ok;
    logic [CODE_W-1:0] code;
  } ctl_map_t;

  function automatic ctl_map_t map_ctl(input logic [LANE_W-1:0] ch);
    ctl_map_t r;
    r.ok = 1'b1;
    unique case (ch)
      8'h07:   r.code = 7'h00;
      8'hFE:   r.code = 7'h1E;
      8'h1C:   r.code = 7'h2D;
      8'h3C:   r.code = 7'h33;
      8'h7C:   r.code = 7'h4B;
      8'hBC:   r.code = 7'h55;
      8'hDC:   r.code = 7'h66;
      8'hF7:   r.code = 7'h78;
      default: begin r.ok = 1'b0; r.code = CODE_ERR; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/enc66_lane_map.sv
module enc66_lane_map
  import enc66_pkg::*;
(
  input  logic [LANE_W-1:0] ch,
  output logic [CODE_W-1:0] code,
  output logic              ok
);
  ctl_map_t m;

  always_comb begin
    m    = map_ctl(ch);
    code = m.code;
    ok   = m.ok;
  end
endmodule

// File: rtl/enc66_frame_pack.sv
module enc66_frame_pack
  import enc66_pkg::*;
#(
  parameter int N_LANES = LANES
) (
  input  logic [N_LANES*LANE_W-1:0]          data,
  input  logic [N_LANES-1:0]                 ctrl,
  output logic [HDR_W+N_LANES*LANE_W-1:0]    frame,
  output logic                               err
);
  localparam int FW = HDR_W + N_LANES * LANE_W;

  logic [CODE_W-1:0] lane_code [N_LANES];
  logic [N_LANES-1:0] lane_ok;
  logic all_ctl, all_dat;

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    enc66_lane_map u_map (
      .ch   (data[k*LANE_W +: LANE_W]),
      .code (lane_code[k]),
      .ok   (lane_ok[k])
    );
  end

  assign all_ctl = &ctrl;
  assign all_dat = ~|ctrl;

  always_comb begin
    frame = '0;
    err   = 1'b0;
    if (all_dat) begin
      frame[HDR_W-1:0]  = HDR_DAT;
      frame[FW-1:HDR_W] = data;
    end else begin
      frame[HDR_W-1:0]               = HDR_CTL;
      frame[CODE_BASE-1:HDR_W]       = TYPE_ALLCT;
      for (int k = 0; k < N_LANES; k++) begin
        frame[CODE_BASE + k*CODE_W +: CODE_W] = all_ctl ? lane_code[k] : CODE_ERR;
      end
      err = !all_ctl || !(&lane_ok);
    end
  end
endmodule

// File: rtl/enc66_ctl_encoder.sv
module enc66_ctl_encoder
  import enc66_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [LANES-1:0]   in_ctrl,
  output logic               out_valid,
  output logic [FRAME_W-1:0] out_frame,
  output logic               out_err
);
  logic [FRAME_W-1:0] frame_nxt;
  logic               err_nxt;
  logic               valid_q, err_q;
  logic [FRAME_W-1:0] frame_q;

  enc66_frame_pack #(.N_LANES(LANES)) u_pack (
    .data  (in_data),
    .ctrl  (in_ctrl),
    .frame (frame_nxt),
    .err   (err_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) err_q <= err_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) frame_q <= frame_nxt;
  end

  assign out_valid = valid_q;
  assign out_frame = frame_q;
  assign out_err   = err_q;

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_valid) |=> ($stable(out_frame) && $stable(out_err))); // R3
  AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ctrl == '0) |=>
      (out_frame[FRAME_W-1:HDR_W] == $past(in_data) && out_frame[1:0] == HDR_DAT && !out_err)); // R4
  AST_CTL_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && &in_ctrl) |=> (out_frame[1:0] == HDR_CTL && out_frame[9:2] == TYPE_ALLCT)); // R5
  AST_ERR_IS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> out_frame[1:0] == HDR_CTL); // R9
endmodule

// File: tb/enc66_ctl_encoder_test.sv
module enc66_ctl_encoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_data;
  logic [7:0]  in_ctrl;
  logic        out_valid;
  logic [65:0] out_frame;
  logic        out_err;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  enc66_ctl_encoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ctrl(in_ctrl), .out_valid(out_valid), .out_frame(out_frame), .out_err(out_err)
  );

  // {kind[1:0], ctrl[7:0], data[63:0]}; kind 0 data, 1 good control, 2 bad char, 3 mixed
  localparam int NV = 8;
  localparam logic [73:0] VEC [NV] = '{
    {2'd0, 8'h00, 64'h0123456789ABCDEF},
    {2'd0, 8'h00, 64'hFFFFFFFF00000000},
    {2'd1, 8'hFF, 64'hF7DCBC7C3C1CFE07},
    {2'd1, 8'hFF, 64'h07FE1C3C7CBCDCF7},
    {2'd1, 8'hFF, 64'h0707070707070707},
    {2'd2, 8'hFF, 64'h0707070707AA0707},
    {2'd2, 8'hFF, 64'h0000000000000000},
    {2'd3, 8'h0F, 64'h1122334407070707}
  };

  function automatic logic [7:0] ref_code(input logic [7:0] c, output logic good);
    good = 1'b1;
    case (c)
      8'h07: return 8'h00;
      8'hFE: return 8'h1E;
      8'h1C: return 8'h2D;
      8'h3C: return 8'h33;
      8'h7C: return 8'h4B;
      8'hBC: return 8'h55;
      8'hDC: return 8'h66;
      8'hF7: return 8'h78;
      default: begin good = 1'b0; return 8'h1E; end
    endcase
  endfunction

  function automatic logic [66:0] ref_block(input logic [7:0] ctl, input logic [63:0] d);
    logic [65:0] f;
    logic e, g;
    logic [7:0] c;
    f = '0; e = 1'b0;
    if (ctl == 8'h00) begin
      f[0] = 1'b0; f[1] = 1'b1;
      for (int i = 0; i < 64; i++) f[2+i] = d[i];
    end else begin
      f[0] = 1'b1; f[1] = 1'b0;
      for (int i = 0; i < 8; i++) f[2+i] = 8'h1E >> i;
      if (ctl != 8'hFF) e = 1'b1;
      for (int k = 0; k < 8; k++) begin
        c = ref_code(d[8*k +: 8], g);
        if (ctl != 8'hFF) c = 8'h1E;
        else if (!g) e = 1'b1;
        for (int j = 0; j < 7; j++) f[10 + 7*k + j] = c[j];
      end
    end
    return {e, f};
  endfunction

  function automatic logic [65:0] from_line(input string s);
    logic [65:0] f;
    f = '0;
    for (int i = 0; i < 66; i++) f[i] = (s[i] == "1");
    return f;
  endfunction

  task automatic chk_frame(input string tag, input logic [65:0] act, input logic [65:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s frame act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [7:0] c, input logic [63:0] d);
    @(negedge clk);
    in_valid = v; in_ctrl = c; in_data = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [65:0] held;
    logic [66:0] r;
    rst_n = 1'b0; in_valid = 1'b0; in_ctrl = '0; in_data = '0;
    repeat (3) @(negedge clk);
    chk_bit("R1", "out_valid in reset", out_valid, 1'b0);
    chk_bit("R1", "out_err in reset", out_err, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_bit("R1", "out_valid after reset", out_valid, 1'b0);

    for (int n = 0; n < NV; n++) begin
      string tag;
      drive(1'b1, VEC[n][71:64], VEC[n][63:0]);
      r = ref_block(VEC[n][71:64], VEC[n][63:0]);
      case (VEC[n][73:72])
        2'd0: tag = "R4";
        2'd1: tag = "R7";
        2'd2: tag = "R8";
        default: tag = "R9";
      endcase
      chk_bit("R2", "out_valid", out_valid, 1'b1);
      chk_frame(tag, out_frame, r[65:0]);
      chk_bit(tag, "out_err", out_err, r[66]);
      if (VEC[n][73:72] < 2) chk_bit("R10", "out_err clear", out_err, 1'b0);
    end

    // R6/R5: lane-order control word against a hand-written line-order bit string
    drive(1'b1, 8'hFF, 64'hF7DCBC7C3C1CFE07);
    chk_frame("R6", out_frame, from_line({"10", "01111000", "0000000", "0111100", "1011010",
                                         "1100110", "1101001", "1010101", "0110011", "0001111"}));
    chk_frame("R5", {58'd0, out_frame[9:0]}, {58'd0, 8'h1E, 2'b01});

    // R3: no valid, new inputs, outputs hold
    held = out_frame;
    drive(1'b0, 8'h5A, 64'hDEADBEEFCAFEF00D);
    chk_bit("R2", "out_valid idle", out_valid, 1'b0);
    chk_frame("R3", out_frame, held);
    chk_bit("R3", "out_err held", out_err, 1'b0);

    // R3: hold after an error word
    drive(1'b1, 8'hF0, 64'h0);
    held = out_frame;
    drive(1'b0, 8'h00, 64'h1);
    chk_frame("R3", out_frame, held);
    chk_bit("R3", "out_err held", out_err, 1'b1);

    // R8: one bad lane at the top, others still mapped
    drive(1'b1, 8'hFF, 64'h3307070707070707);
    chk_frame("R8", {59'd0, out_frame[65:59]}, {59'd0, 7'h1E});
    chk_frame("R8", {59'd0, out_frame[16:10]}, {59'd0, 7'h00});
    chk_bit("R8", "out_err", out_err, 1'b1);

    // R1: reset during a run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_bit("R1", "out_valid async reset", out_valid, 1'b0);
    chk_bit("R1", "out_err async reset", out_err, 1'b0);
    @(negedge clk);
    rst_n = 1'b1; in_valid = 1'b0;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule